// File: doc/BRIEF.md
# Parallel concatenated turbo encoder

This block turns a fixed-length binary frame into a rate-1/3 turbo codeword. It stores the incoming frame and then runs two identical recursive systematic convolutional encoders side by side. The first encoder reads the frame in natural order. The second reads it through an index table that acts as the interleaver. Each encoder has feedback polynomial 1 + D^2 + D^3, parity polynomial 1 + D + D^3, eight states, and starts every frame from the all-zero state.

The codeword leaves the block as a serial bit stream with valid/ready flow control. The body sends, for each frame position in turn, the systematic bit, the first parity bit and the second parity bit. The systematic stream of the second encoder is left out of the body. After the body come the termination bits. First the first encoder's three tail steps are sent, then the second encoder's three tail steps. Each tail step sends its systematic bit and then its parity bit. With the default 64-bit frame a codeword is 3*64 + 12 = 204 bits.

The interleaver table holds one 1-based frame index per encoder step. Software can load it through a write port. After reset the block rewrites it to the full reversal. A table that is not a permutation of 1..L raises an error flag and stops frame intake.

Top module: `turbo_encoder`

## Requirements
- R1: While reset is held and directly after it is released, out_valid is low, tbl_err is low and in_ready is low. After the table initialisation finishes, which takes about FRAME_LEN cycles, in_ready rises.
- R2: Frame bits are taken when in_valid and in_ready are both high at a clock edge. The first bit taken is frame position 1. in_ready is low from the moment the last bit of a frame is taken until the last codeword bit is accepted. It is high again in the cycle after that.
- R3: Each frame produces exactly 3*FRAME_LEN + 4*MEM bits (204 by default). out_last is high on the final bit only and is never high without out_valid.
- R4: Body triplet k (k = 0..FRAME_LEN-1) is output as bit 3k, bit 3k+1 and bit 3k+2. Bit 3k is frame bit k. Bit 3k+1 is the first encoder's parity after frame bits 0..k. Encoder state update: feedback f = u ^ s2 ^ s3, parity = f ^ s1 ^ s3, with s1 the newest state bit.
- R5: With the default table, the second encoder's input at step k is frame bit FRAME_LEN-1-k, so the table entry at address k is FRAME_LEN-k. That encoder's parity is body bit 3k+2.
- R6: After the body, each encoder runs MEM termination steps whose input equals its feedback, first encoder 1 and then encoder 2. Every step sends the input bit and then the parity bit. Both encoders are back in the all-zero state when the final bit is accepted.
- R7: Writing value v (1..FRAME_LEN) to table address a makes the second encoder's input at step a equal to frame bit v-1. A write takes effect only while the block is idle with no frame bits stored and the table initialisation has finished. While tbl_wr_en is high, in_ready is low.
- R8: If any table entry is 0, is greater than FRAME_LEN, or repeats another entry, tbl_err goes high and in_ready is held low. Rewriting the table back to a permutation clears tbl_err.
- R9: Table writes made while a frame is partly stored or while a codeword is being output have no effect on the table, on the codeword or on tbl_err.
- R10: While out_valid is high and out_ready is low, out_valid, out_bit and out_last stay unchanged at the next edge. No codeword bit is lost or repeated.
- R11: Reset restores the reversal table, whatever was loaded before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame bit offered |
| in_bit | input | 1 | Frame bit value |
| in_ready | output | 1 | Block takes a frame bit this cycle |
| tbl_wr_en | input | 1 | Interleaver table write request |
| tbl_wr_addr | input | 6 | Table address (0-based encoder step) |
| tbl_wr_val | input | 7 | 1-based frame index to store |
| tbl_err | output | 1 | Table is not a valid permutation |
| out_valid | output | 1 | Codeword bit available |
| out_bit | output | 1 | Codeword bit value |
| out_last | output | 1 | Final bit of the codeword |
| out_ready | input | 1 | Consumer accepts the codeword bit |

## Verification
The bench builds the block with its defaults: 64-bit frames, three memory cells and the 13/15 octal polynomials. This lets the full 204-bit codeword, including both tail groups, be compared bit for bit against a bench model. Random permutations written into the 64-entry table reach every second-encoder index. Directed writes of zero, of 100 and of duplicate values exercise the range and uniqueness checks. Random out_ready duty cycles of 50 to 100 percent drive the serializer through both steady streaming and held bits.

// File: rtl/turbo_pkg.sv
package turbo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME,
    ST_BODY,
    ST_TAIL_A,
    ST_TAIL_B,
    ST_DRAIN
  } enc_state_e;
endpackage

// File: rtl/turbo_rsc.sv
module turbo_rsc #(
  parameter int         MEM     = 3,
  parameter logic [3:0] FB_POLY = 4'b1011,
  parameter logic [3:0] FF_POLY = 4'b1101
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           step,
  input  logic           term,
  input  logic           u,
  output logic           sys_o,
  output logic           par_o,
  output logic [MEM-1:0] state_o
);
  logic [MEM-1:0] st;
  logic fb_taps, u_eff, fb_bit, ff_acc;

  // State bit k-1 holds the value delayed by k steps; polynomial MSB is D^0.
  always_comb begin
    fb_taps = 1'b0;
    for (int k = 1; k <= MEM; k++) fb_taps = fb_taps ^ (FB_POLY[MEM-k] & st[k-1]);
    u_eff  = term ? fb_taps : u;
    fb_bit = u_eff ^ fb_taps;
    ff_acc = FF_POLY[MEM] & fb_bit;
    for (int k = 1; k <= MEM; k++) ff_acc = ff_acc ^ (FF_POLY[MEM-k] & st[k-1]);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) st <= '0;
    else if (step)    st <= {st[MEM-2:0], fb_bit};
  end

  assign sys_o   = u_eff;
  assign par_o   = ff_acc;
  assign state_o = st;
endmodule

// File: rtl/turbo_perm_table.sv
module turbo_perm_table #(
  parameter  int FRAME_LEN = 64,
  localparam int AW = $clog2(FRAME_LEN),
  localparam int VW = $clog2(FRAME_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_take,
  input  logic [AW-1:0] wr_addr,
  input  logic [VW-1:0] wr_val,
  input  logic [AW-1:0] rd_addr,
  output logic [VW-1:0] rd_val,
  output logic          ready_o,
  output logic          busy_o,
  output logic          err_o
);
  logic [VW-1:0] mem [FRAME_LEN];
  logic [VW-1:0] rd_q;
  logic          init_act;
  logic [AW-1:0] init_cnt;
  logic          pend, fwd;
  logic [AW-1:0] p_addr;
  logic [VW-1:0] p_val, fwd_val;
  logic          mem_we;
  logic [AW-1:0] mem_wa, mem_ra;
  logic [VW-1:0] mem_wd, old_val;
  logic          old_ok, new_ok;
  logic [FRAME_LEN-1:0] miss;
  logic [VW-1:0] bad_q;

  always_comb begin
    mem_we  = init_act | pend;
    mem_wa  = init_act ? init_cnt : p_addr;
    mem_wd  = init_act ? (VW'(FRAME_LEN) - VW'(init_cnt)) : p_val;
    mem_ra  = wr_take ? wr_addr : rd_addr;
    old_val = fwd ? fwd_val : rd_q;
    old_ok  = (old_val != '0) && (old_val <= VW'(FRAME_LEN));
    new_ok  = (p_val != '0) && (p_val <= VW'(FRAME_LEN));
  end

  // Plain single-write, registered-read memory.
  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
    rd_q <= mem[mem_ra];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_act <= 1'b1;
      init_cnt <= '0;
      pend     <= 1'b0;
      fwd      <= 1'b0;
      p_addr   <= '0;
      p_val    <= '0;
      fwd_val  <= '0;
      bad_q    <= '0;
    end else begin
      if (init_act) begin
        init_cnt <= init_cnt + 1'b1;
        if (init_cnt == AW'(FRAME_LEN - 1)) init_act <= 1'b0;
      end
      pend <= wr_take;
      if (wr_take) begin
        p_addr  <= wr_addr;
        p_val   <= wr_val;
        fwd     <= pend && (p_addr == wr_addr);
        fwd_val <= p_val;
      end
      if (pend) bad_q <= bad_q + VW'(!new_ok) - VW'(!old_ok);
    end
  end

  // One occupancy counter per legal index value.
  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_occ
    logic [VW-1:0] cnt_q;
    logic hit_new, hit_old;
    assign hit_new = new_ok && (p_val == VW'(g + 1));
    assign hit_old = old_ok && (old_val == VW'(g + 1));
    always_ff @(posedge clk) begin
      if (rst)       cnt_q <= VW'(1);
      else if (pend) cnt_q <= cnt_q + VW'(hit_new) - VW'(hit_old);
    end
    assign miss[g] = (cnt_q == '0);
  end

  assign rd_val  = rd_q;
  assign ready_o = !init_act;
  assign busy_o  = pend;
  assign err_o   = (|miss) || (bad_q != '0);

  // R7: writes only after the reversal sweep is done
  a_r7_write_after_init: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> !init_act);
  // R8: committing an out-of-range value must flag the table
  a_r8_bad_value_flags: assert property (@(posedge clk) disable iff (rst)
    pend && !new_ok |=> err_o);
endmodule

// File: rtl/turbo_encoder.sv
module turbo_encoder
  import turbo_pkg::*;
#(
  parameter  int         FRAME_LEN = 64,
  parameter  int         MEM       = 3,
  parameter  logic [3:0] FB_POLY   = 4'b1011,
  parameter  logic [3:0] FF_POLY   = 4'b1101,
  localparam int         AW        = $clog2(FRAME_LEN),
  localparam int         VW        = $clog2(FRAME_LEN + 1),
  localparam int         TW        = $clog2(MEM + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_bit,
  output logic          in_ready,
  input  logic          tbl_wr_en,
  input  logic [AW-1:0] tbl_wr_addr,
  input  logic [VW-1:0] tbl_wr_val,
  output logic          tbl_err,
  output logic          out_valid,
  output logic          out_bit,
  output logic          out_last,
  input  logic          out_ready
);
  enc_state_e st;
  logic [FRAME_LEN-1:0] frame_q;
  logic [AW-1:0] wptr, pos;
  logic [TW-1:0] tstep;
  logic [VW-1:0] tbl_rd_val;
  logic tbl_ready, tbl_busy, wr_take, in_take;
  logic [2:0] sh_bit, sh_vld, sh_last;
  logic free, acc, load_body, load_a, load_b, tstep_end;
  logic [1:0] enc_u, enc_step, enc_term, enc_sys, enc_par;
  logic [MEM-1:0] enc_state [2];
  logic [AW-1:0] idx2;

  assign wr_take  = tbl_wr_en && (st == ST_IDLE) && (wptr == '0) && tbl_ready;
  assign in_ready = (st == ST_IDLE) && tbl_ready && !tbl_busy && !tbl_err && !tbl_wr_en;
  assign in_take  = in_valid && in_ready;

  turbo_perm_table #(.FRAME_LEN(FRAME_LEN)) perm_i (
    .clk(clk), .rst(rst), .wr_take(wr_take), .wr_addr(tbl_wr_addr),
    .wr_val(tbl_wr_val), .rd_addr(pos), .rd_val(tbl_rd_val),
    .ready_o(tbl_ready), .busy_o(tbl_busy), .err_o(tbl_err));

  assign acc       = sh_vld[0] && out_ready;
  assign free      = !sh_vld[0] || (out_ready && !sh_vld[1]);
  assign load_body = (st == ST_BODY) && free;
  assign load_a    = (st == ST_TAIL_A) && free;
  assign load_b    = (st == ST_TAIL_B) && free;
  assign tstep_end = (tstep == TW'(MEM - 1));
  assign idx2      = AW'(tbl_rd_val - VW'(1));

  assign enc_u    = {frame_q[idx2], frame_q[pos]};
  assign enc_step = {load_body || load_b, load_body || load_a};
  assign enc_term = {st == ST_TAIL_B, st == ST_TAIL_A};

  for (genvar e = 0; e < 2; e++) begin : g_enc
    turbo_rsc #(.MEM(MEM), .FB_POLY(FB_POLY), .FF_POLY(FF_POLY)) rsc_i (
      .clk(clk), .rst(rst), .clear(st == ST_PRIME), .step(enc_step[e]),
      .term(enc_term[e]), .u(enc_u[e]), .sys_o(enc_sys[e]),
      .par_o(enc_par[e]), .state_o(enc_state[e]));
  end

  // Control: frame capture, body walk, two tail groups, drain.
  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      wptr  <= '0;
      pos   <= '0;
      tstep <= '0;
    end else begin
      case (st)
        ST_IDLE: if (in_take) begin
          frame_q[wptr] <= in_bit;
          wptr <= wptr + 1'b1;
          if (wptr == AW'(FRAME_LEN - 1)) begin
            wptr <= '0;
            st   <= ST_PRIME;
          end
        end
        ST_PRIME: st <= ST_BODY;
        ST_BODY: if (free) begin
          pos <= pos + 1'b1;
          if (pos == AW'(FRAME_LEN - 1)) begin
            pos   <= '0;
            tstep <= '0;
            st    <= ST_TAIL_A;
          end
        end
        ST_TAIL_A: if (free) begin
          tstep <= tstep_end ? '0 : tstep + 1'b1;
          if (tstep_end) st <= ST_TAIL_B;
        end
        ST_TAIL_B: if (free) begin
          tstep <= tstep_end ? '0 : tstep + 1'b1;
          if (tstep_end) st <= ST_DRAIN;
        end
        ST_DRAIN: if (free) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Output serializer: bit 0 is the bit on the port.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_bit  <= '0;
      sh_vld  <= '0;
      sh_last <= '0;
    end else if (load_body) begin
      sh_bit  <= {enc_par[1], enc_par[0], enc_sys[0]};
      sh_vld  <= 3'b111;
      sh_last <= 3'b000;
    end else if (load_a || load_b) begin
      sh_bit  <= load_a ? {1'b0, enc_par[0], enc_sys[0]} : {1'b0, enc_par[1], enc_sys[1]};
      sh_vld  <= 3'b011;
      sh_last <= (load_b && tstep_end) ? 3'b010 : 3'b000;
    end else if (acc) begin
      sh_bit  <= {1'b0, sh_bit[2:1]};
      sh_vld  <= {1'b0, sh_vld[2:1]};
      sh_last <= {1'b0, sh_last[2:1]};
    end
  end

  assign out_valid = sh_vld[0];
  assign out_bit   = sh_bit[0];
  assign out_last  = sh_last[0];

  // R3: last marker only on a valid bit
  a_r3_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R10: held bit stays put under backpressure
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_last));
  // R2: no frame intake while a codeword is pending
  a_r2_no_intake_while_output: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid);
  // R8: a broken table blocks intake
  a_r8_err_blocks_intake: assert property (@(posedge clk) disable iff (rst)
    tbl_err |-> !in_ready);
  // R6: both encoders terminated when the final bit leaves
  a_r6_terminated_at_last: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |-> (enc_state[0] == '0) && (enc_state[1] == '0));
endmodule

// File: tb/turbo_encoder_tb_top.sv
module turbo_encoder_tb_top;
  localparam int L          = 64;
  localparam int M          = 3;
  localparam int AW         = $clog2(L);
  localparam int VW         = $clog2(L + 1);
  localparam int NOUT       = 3 * L + 4 * M;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, in_ready;
  logic tbl_wr_en = 1'b0;
  logic [AW-1:0] tbl_wr_addr = '0;
  logic [VW-1:0] tbl_wr_val = '0;
  logic tbl_err, out_valid, out_bit, out_last;
  logic out_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit fr [L];
  int perm_m [L];
  bit exp_cw [NOUT];

  always #(CLK_PERIOD/2) clk = ~clk;

  turbo_encoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_val(tbl_wr_val),
    .tbl_err(tbl_err), .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last),
    .out_ready(out_ready));

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic void make_expected();
    bit [2:0] a = '0;
    bit [2:0] b = '0;
    bit x, y, f, p, q;
    int k = 0;
    for (int i = 0; i < L; i++) begin
      x = fr[i];
      y = fr[perm_m[i] - 1];
      f = x ^ a[1] ^ a[2]; p = f ^ a[0] ^ a[2]; a = {a[1], a[0], f};
      f = y ^ b[1] ^ b[2]; q = f ^ b[0] ^ b[2]; b = {b[1], b[0], f};
      exp_cw[k] = x; exp_cw[k+1] = p; exp_cw[k+2] = q;
      k += 3;
    end
    for (int t = 0; t < M; t++) begin
      exp_cw[k] = a[1] ^ a[2]; exp_cw[k+1] = a[0] ^ a[2]; a = {a[1], a[0], 1'b0};
      k += 2;
    end
    for (int t = 0; t < M; t++) begin
      exp_cw[k] = b[1] ^ b[2]; exp_cw[k+1] = b[0] ^ b[2]; b = {b[1], b[0], 1'b0};
      k += 2;
    end
  endfunction

  task automatic set_reversal();
    for (int i = 0; i < L; i++) perm_m[i] = L - i;
  endtask

  task automatic fill_frame(input int mode);
    for (int i = 0; i < L; i++) fr[i] = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : bit'($urandom % 2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; tbl_wr_en = 1'b0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!in_ready && n < 300) begin @(negedge clk); n++; end
    check(in_ready, req, "in_ready after wait", int'(in_ready), 1);
  endtask

  task automatic tbl_write(input int a, input int v);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = AW'(a); tbl_wr_val = VW'(v);
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic send_frame(input int poke_at);
    int i = 0;
    bit poked = 1'b0;
    while (i < L) begin
      @(negedge clk);
      tbl_wr_en = 1'b0;
      if (poke_at >= 0 && i == poke_at && !poked) begin
        tbl_wr_en = 1'b1; tbl_wr_addr = AW'(0); tbl_wr_val = VW'(9); poked = 1'b1;
      end
      in_valid = ($urandom % 4) != 0;
      in_bit = fr[i];
      #1;
      if (tbl_wr_en) check(!in_ready, "R7", "in_ready during write cycle", int'(in_ready), 0);
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0; tbl_wr_en = 1'b0;
  endtask

  task automatic collect(input int rdy_pct, input bit poke, input string ztag);
    int n = 0;
    int guard = 0;
    bit hold = 1'b0, pb = 1'b0, pl = 1'b0, poked = 1'b0;
    string tag;
    while (n < NOUT && guard < 5000) begin
      @(negedge clk);
      guard++;
      tbl_wr_en = 1'b0;
      if (poke && !poked && n >= 50) begin
        tbl_wr_en = 1'b1; tbl_wr_addr = AW'(3); tbl_wr_val = VW'(9); poked = 1'b1;
      end
      if (hold) check(out_valid && out_bit == pb && out_last == pl, "R10", "held bit changed",
                      int'({out_valid, out_bit, out_last}), int'({1'b1, pb, pl}));
      check(!in_ready, "R2", "in_ready during output", int'(in_ready), 0);
      out_ready = ($urandom % 100) < rdy_pct;
      hold = out_valid && !out_ready; pb = out_bit; pl = out_last;
      if (out_valid && out_ready) begin
        if (n >= 3 * L) tag = "R6";
        else if (n % 3 == 2) tag = ztag;
        else tag = "R4";
        check(out_bit == exp_cw[n], tag, $sformatf("codeword bit %0d", n), int'(out_bit), int'(exp_cw[n]));
        check(out_last == (n == NOUT - 1), "R3", $sformatf("last flag at bit %0d", n), int'(out_last), int'(n == NOUT - 1));
        n++;
      end
    end
    tbl_wr_en = 1'b0;
    check(n == NOUT, "R3", "codeword length", n, NOUT);
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid, "R3", "no bit after last", int'(out_valid), 0);
    check(in_ready, "R2", "in_ready back after codeword", int'(in_ready), 1);
  endtask

  task automatic run_frame(input int mode, input int rdy_pct, input int poke_at, input bit poke_out, input string ztag);
    fill_frame(mode);
    make_expected();
    send_frame(poke_at);
    collect(rdy_pct, poke_out, ztag);
  endtask

  task automatic load_random_perm();
    int j, t;
    for (int i = 0; i < L; i++) perm_m[i] = i + 1;
    for (int i = L - 1; i > 0; i--) begin
      j = int'($urandom % (i + 1));
      t = perm_m[i]; perm_m[i] = perm_m[j]; perm_m[j] = t;
    end
    for (int i = 0; i < L; i++) tbl_write(i, perm_m[i]);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    set_reversal();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
    check(!tbl_err, "R1", "tbl_err in reset", int'(tbl_err), 0);
    check(!in_ready, "R1", "in_ready in reset", int'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!in_ready, "R1", "in_ready during table init", int'(in_ready), 0);
    wait_ready("R1");

    // R4 R5 R6: default reversal, streaming and throttled
    run_frame(2, 100, -1, 1'b0, "R5");
    run_frame(1, 50, -1, 1'b0, "R5");
    run_frame(0, 70, -1, 1'b0, "R5");

    // R9: writes during partial frame and during output are ignored
    run_frame(2, 60, 20, 1'b1, "R9");
    check(!tbl_err, "R9", "tbl_err after ignored writes", int'(tbl_err), 0);

    // R7: loaded permutation drives encoder 2
    load_random_perm();
    check(!tbl_err, "R8", "tbl_err after valid permutation", int'(tbl_err), 0);
    run_frame(2, 80, -1, 1'b0, "R7");
    run_frame(2, 100, -1, 1'b0, "R7");

    // R8: zero, out-of-range and duplicate entries
    tbl_write(5, 0);
    repeat (2) @(negedge clk);
    check(tbl_err, "R8", "tbl_err with zero entry", int'(tbl_err), 1);
    in_valid = 1'b1;
    repeat (4) begin
      @(negedge clk); #1;
      check(!in_ready, "R8", "in_ready with bad table", int'(in_ready), 0);
    end
    in_valid = 1'b0;
    tbl_write(5, 100);
    repeat (2) @(negedge clk);
    check(tbl_err, "R8", "tbl_err with entry above length", int'(tbl_err), 1);
    tbl_write(5, perm_m[6]);
    repeat (2) @(negedge clk);
    check(tbl_err, "R8", "tbl_err with duplicate entry", int'(tbl_err), 1);
    tbl_write(5, perm_m[5]);
    repeat (2) @(negedge clk);
    check(!tbl_err, "R8", "tbl_err after repair", int'(tbl_err), 0);
    check(in_ready, "R8", "in_ready after repair", int'(in_ready), 1);
    run_frame(2, 75, -1, 1'b0, "R7");

    // R11: reset brings back the reversal table
    do_reset();
    set_reversal();
    wait_ready("R11");
    run_frame(2, 90, -1, 1'b0, "R11");
    run_frame(2, 55, -1, 1'b0, "R5");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule